// File: doc/BRIEF.md
# Programmable-Rate Serial Result Transmitter

This block sits on the device side of a serial link. It sends one 16-bit measurement to a host, and it is the clock master of that link. The host asks for a result by pulling an active-low request line low. The block then starts an external measurement engine through a start/done handshake. When the engine reports completion, the block drives a serial clock and a data line and shifts the result out as two bytes, with a programmable pause between the bytes. An active-low ready line marks the whole transfer, so a host that watches it knows when data is on the wire.

All timing comes from a clock-enable input that pulses at 1.2 MHz. A full serial clock period lasts 30 + 8·R enables, where R is the 8-bit rate setting. The pause between the bytes lasts 10 + 4·G enables, where G is the 8-bit gap setting. A mode input selects whether the clock rests low or high. Data always changes on the edge that leaves the rest level. If the host still holds the request low when the engine finishes, the block sends nothing. It raises a setup-mode flag instead and stays there until reset.

Top module: `serial_result_tx`

## Requirements
- R1: After reset, sclk sits at the level chosen by cfg_idle_high, sdo is 0, drdy_n is 1, setup_mode is 0 and meas_start is 0.
- R2: In idle, a low level on req_n makes meas_start high for exactly one clock. No clock edge appears and drdy_n stays high until meas_done is seen.
- R3: On meas_done (with req_n high), the 16-bit meas_data is sent MSB first, bits 15..8 before bits 7..0. sdo takes each bit at the edge where sclk leaves its rest level.
- R4: Inside a byte, consecutive leaving edges are exactly 30 + 8·cfg_rate tick_en pulses apart. Timing counters advance only on tick_en.
- R5: Each bit keeps sclk away from its rest level for floor(P/2) tick_en pulses, where P is the period from R4. The remaining ceil(P/2) pulses are spent at the rest level.
- R6: From the leaving edge of bit 7 of the high byte to the leaving edge of the first bit of the low byte, the interval is P + 10 + 4·cfg_gap tick_en pulses.
- R7: cfg_idle_high = 0 gives a clock resting low, so data changes on rising edges. cfg_idle_high = 1 gives a clock resting high, so data changes on falling edges.
- R8: sdo is 0 whenever no bit is being sent, which includes the pause between the bytes.
- R9: drdy_n goes low at the first leaving edge of the high byte. It stays low through all 16 bits and returns high exactly P tick_en pulses after the last leaving edge.
- R10: If req_n is low in the cycle meas_done arrives, no bit is sent, drdy_n stays high and setup_mode goes high. setup_mode stays high, and later requests produce no meas_start until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | 1.2 MHz timebase enable, one clk wide |
| req_n | input | 1 | Active-low request, synchronous to clk |
| cfg_rate | input | 8 | Serial clock rate setting R |
| cfg_gap | input | 8 | Inter-byte gap setting G |
| cfg_idle_high | input | 1 | 1 = clock rests high, 0 = rests low |
| meas_data | input | 16 | Result from the measurement engine |
| meas_done | input | 1 | One-cycle completion strobe from the engine |
| meas_start | output | 1 | One-cycle acquisition start strobe |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data |
| drdy_n | output | 1 | Active-low transfer frame |
| setup_mode | output | 1 | Setup-mode entry flag |

## Verification
Transfers are tried with the default settings and a clock resting low, then with the minimum rate and gap and a clock resting high, then with a small odd-valued pair of settings. The data words use alternating, asymmetric and byte-distinct patterns, so a swapped byte order, a reversed bit order or a stuck bit gives a different word. The timebase enable arrives at irregular intervals, and every interval is measured in counted enables. This separates counters that correctly follow tick_en from counters that run on the clock, and it shows whether the period, the half-period and the gap formula each hold on their own. A request still held low at completion is checked for the setup diversion and for the requests ignored after it.

// File: rtl/srt_pkg.sv
package srt_pkg;

    localparam int DATA_W   = 16;
    localparam int BYTE_W   = 8;
    localparam int CFG_W    = 8;
    localparam int TICK_W   = 12;
    localparam int BITCNT_W = $clog2(BYTE_W);

    localparam int PER_BASE = 30;
    localparam int PER_STEP = 8;
    localparam int GAP_BASE = 10;
    localparam int GAP_STEP = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACQ,
        ST_BIT,
        ST_GAP,
        ST_SETUP
    } srt_state_e;

    typedef struct packed {
        logic              load;
        logic [TICK_W-1:0] value;
    } timer_cmd_t;

    typedef struct packed {
        logic load_word;
        logic present;
        logic clear;
    } shift_cmd_t;

    function automatic logic [TICK_W-1:0] period_ticks(input logic [CFG_W-1:0] rate);
        return TICK_W'(PER_BASE + PER_STEP * int'(rate));
    endfunction

    function automatic logic [TICK_W-1:0] active_ticks(input logic [CFG_W-1:0] rate);
        logic [TICK_W-1:0] p;
        p = period_ticks(rate);
        return p >> 1;
    endfunction

    function automatic logic [TICK_W-1:0] rest_ticks(input logic [CFG_W-1:0] rate);
        logic [TICK_W-1:0] p;
        p = period_ticks(rate);
        return p - (p >> 1);
    endfunction

    function automatic logic [TICK_W-1:0] gap_ticks(input logic [CFG_W-1:0] gap);
        return TICK_W'(GAP_BASE + GAP_STEP * int'(gap));
    endfunction

endpackage

// File: rtl/srt_timer.sv
module srt_timer
    import srt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_en,
    input  timer_cmd_t cmd,
    output logic       expire
);

    logic [TICK_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (cmd.load) begin
            cnt <= cmd.value;
        end else if (tick_en && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expire = tick_en && (cnt == TICK_W'(1));

    // R4: the count must not move between tick_en pulses
    assert_hold_without_tick_R4: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !cmd.load) |=> $stable(cnt));

endmodule

// File: rtl/srt_shifter.sv
module srt_shifter
    import srt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  shift_cmd_t        cmd,
    input  logic [DATA_W-1:0] word,
    output logic              sdo
);

    logic [DATA_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            sdo   <= 1'b0;
        end else if (cmd.load_word) begin
            sdo   <= word[DATA_W-1];
            shreg <= word << 1;
        end else if (cmd.present) begin
            sdo   <= shreg[DATA_W-1];
            shreg <= shreg << 1;
        end else if (cmd.clear) begin
            sdo   <= 1'b0;
        end
    end

    // R8: a cleared line reads low on the next cycle
    assert_sdo_cleared_R8: assert property (@(posedge clk) disable iff (rst)
        (cmd.clear && !cmd.load_word && !cmd.present) |=> !sdo);

endmodule

// File: rtl/srt_ctrl.sv
module srt_ctrl
    import srt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_n,
    input  logic             meas_done,
    input  logic [CFG_W-1:0] cfg_rate,
    input  logic [CFG_W-1:0] cfg_gap,
    input  logic             tmr_expire,
    output timer_cmd_t       tmr_cmd,
    output shift_cmd_t       sh_cmd,
    output logic             clk_active,
    output logic             drdy_n,
    output logic             meas_start,
    output logic             setup_mode
);

    srt_state_e            state_q, state_d;
    logic [BITCNT_W-1:0]   bits_q, bits_d;
    logic                  hi_q, hi_d;
    logic                  act_q, act_d;
    logic                  drdy_q, drdy_d;
    logic                  start_q, start_d;
    logic                  setup_q, setup_d;

    always_comb begin
        state_d       = state_q;
        bits_d        = bits_q;
        hi_d          = hi_q;
        act_d         = act_q;
        drdy_d        = drdy_q;
        start_d       = 1'b0;
        setup_d       = setup_q;
        tmr_cmd.load  = 1'b0;
        tmr_cmd.value = '0;
        sh_cmd        = '0;

        unique case (state_q)
            ST_IDLE: begin
                if (!req_n) begin
                    start_d = 1'b1;
                    state_d = ST_ACQ;
                end
            end
            ST_ACQ: begin
                if (meas_done) begin
                    if (!req_n) begin
                        setup_d = 1'b1;
                        state_d = ST_SETUP;
                    end else begin
                        sh_cmd.load_word = 1'b1;
                        act_d            = 1'b1;
                        drdy_d           = 1'b0;
                        bits_d           = BITCNT_W'(BYTE_W - 1);
                        hi_d             = 1'b1;
                        tmr_cmd.load     = 1'b1;
                        tmr_cmd.value    = active_ticks(cfg_rate);
                        state_d          = ST_BIT;
                    end
                end
            end
            ST_BIT: begin
                if (tmr_expire) begin
                    if (act_q) begin
                        act_d         = 1'b0;
                        tmr_cmd.load  = 1'b1;
                        tmr_cmd.value = rest_ticks(cfg_rate);
                    end else if (bits_q != '0) begin
                        bits_d         = bits_q - 1'b1;
                        act_d          = 1'b1;
                        sh_cmd.present = 1'b1;
                        tmr_cmd.load   = 1'b1;
                        tmr_cmd.value  = active_ticks(cfg_rate);
                    end else if (hi_q) begin
                        hi_d          = 1'b0;
                        sh_cmd.clear  = 1'b1;
                        tmr_cmd.load  = 1'b1;
                        tmr_cmd.value = gap_ticks(cfg_gap);
                        state_d       = ST_GAP;
                    end else begin
                        sh_cmd.clear = 1'b1;
                        drdy_d       = 1'b1;
                        state_d      = ST_IDLE;
                    end
                end
            end
            ST_GAP: begin
                if (tmr_expire) begin
                    bits_d         = BITCNT_W'(BYTE_W - 1);
                    act_d          = 1'b1;
                    sh_cmd.present = 1'b1;
                    tmr_cmd.load   = 1'b1;
                    tmr_cmd.value  = active_ticks(cfg_rate);
                    state_d        = ST_BIT;
                end
            end
            ST_SETUP: begin
                state_d = ST_SETUP;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            bits_q  <= '0;
            hi_q    <= 1'b0;
            act_q   <= 1'b0;
            drdy_q  <= 1'b1;
            start_q <= 1'b0;
            setup_q <= 1'b0;
        end else begin
            state_q <= state_d;
            bits_q  <= bits_d;
            hi_q    <= hi_d;
            act_q   <= act_d;
            drdy_q  <= drdy_d;
            start_q <= start_d;
            setup_q <= setup_d;
        end
    end

    assign clk_active = act_q;
    assign drdy_n     = drdy_q;
    assign meas_start = start_q;
    assign setup_mode = setup_q;

    // R2: the start strobe is a single cycle
    assert_start_single_R2: assert property (@(posedge clk) disable iff (rst)
        meas_start |=> !meas_start);

    // R9: the frame is released while waiting or idle
    assert_frame_released_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE || state_q == ST_ACQ) |-> drdy_n);

    // R10: setup mode is sticky and silent
    assert_setup_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        setup_mode |=> setup_mode);
    assert_setup_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        setup_mode |-> (drdy_n && !clk_active && !meas_start));

endmodule

// File: rtl/serial_result_tx.sv
module serial_result_tx
    import srt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              req_n,
    input  logic [CFG_W-1:0]  cfg_rate,
    input  logic [CFG_W-1:0]  cfg_gap,
    input  logic              cfg_idle_high,
    input  logic [DATA_W-1:0] meas_data,
    input  logic              meas_done,
    output logic              meas_start,
    output logic              sclk,
    output logic              sdo,
    output logic              drdy_n,
    output logic              setup_mode
);

    timer_cmd_t tmr_cmd;
    shift_cmd_t sh_cmd;
    logic       tmr_expire;
    logic       clk_active;

    srt_timer u_timer (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .cmd     (tmr_cmd),
        .expire  (tmr_expire)
    );

    srt_shifter u_shifter (
        .clk  (clk),
        .rst  (rst),
        .cmd  (sh_cmd),
        .word (meas_data),
        .sdo  (sdo)
    );

    srt_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req_n      (req_n),
        .meas_done  (meas_done),
        .cfg_rate   (cfg_rate),
        .cfg_gap    (cfg_gap),
        .tmr_expire (tmr_expire),
        .tmr_cmd    (tmr_cmd),
        .sh_cmd     (sh_cmd),
        .clk_active (clk_active),
        .drdy_n     (drdy_n),
        .meas_start (meas_start),
        .setup_mode (setup_mode)
    );

    assign sclk = clk_active ^ cfg_idle_high;

    // R7: the clock leaves its rest level only inside a frame
    assert_rest_level_R7: assert property (@(posedge clk) disable iff (rst)
        drdy_n |-> (sclk == cfg_idle_high));

    // R8: no data on the line outside a frame
    assert_sdo_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        drdy_n |-> !sdo);

endmodule

// File: tb/serial_result_tx_tb.sv
module serial_result_tx_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        req_n = 1'b1;
    logic [7:0]  cfg_rate = 8'd55;
    logic [7:0]  cfg_gap = 8'd148;
    logic        cfg_idle_high = 1'b0;
    logic [15:0] meas_data = '0;
    logic        meas_done = 1'b0;
    logic        meas_start;
    logic        sclk;
    logic        sdo;
    logic        drdy_n;
    logic        setup_mode;

    int checks = 0;
    int fails = 0;

    int tick_cnt = 0;
    bit mon_on = 1'b0;
    bit mon_idle = 1'b0;
    int nlead, ntrail;
    int lead_t[16];
    int trail_t[16];
    logic lead_d[16];
    int drdy_rise_t;
    int drdy_bad;
    logic sdo_before_b1;
    logic prev_sclk = 1'b0;
    logic prev_sdo = 1'b0;
    logic prev_drdy = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_result_tx u_dut (
        .clk           (clk),
        .rst           (rst),
        .tick_en       (tick_en),
        .req_n         (req_n),
        .cfg_rate      (cfg_rate),
        .cfg_gap       (cfg_gap),
        .cfg_idle_high (cfg_idle_high),
        .meas_data     (meas_data),
        .meas_done     (meas_done),
        .meas_start    (meas_start),
        .sclk          (sclk),
        .sdo           (sdo),
        .drdy_n        (drdy_n),
        .setup_mode    (setup_mode)
    );

    // irregular timebase: one-cycle pulse, then 1 to 3 quiet cycles
    initial begin
        int k;
        k = 0;
        forever begin
            @(negedge clk) tick_en = 1'b1;
            @(negedge clk) tick_en = 1'b0;
            repeat (k % 3) @(negedge clk);
            k++;
        end
    end

    always @(posedge clk) if (tick_en) tick_cnt++;

    always @(negedge clk) begin
        if (mon_on) begin
            if (sclk != mon_idle && prev_sclk == mon_idle) begin
                if (nlead < 16) begin
                    lead_t[nlead] = tick_cnt;
                    lead_d[nlead] = sdo;
                    if (nlead == 8) sdo_before_b1 = prev_sdo;
                end
                nlead++;
                if (drdy_n) drdy_bad++;
            end
            if (sclk == mon_idle && prev_sclk != mon_idle) begin
                if (ntrail < 16) trail_t[ntrail] = tick_cnt;
                ntrail++;
            end
            if (!prev_drdy && drdy_n) drdy_rise_t = tick_cnt;
        end
        prev_sclk = sclk;
        prev_sdo  = sdo;
        prev_drdy = drdy_n;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        req_n = 1'b1;
        meas_done = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic test_reset_state();
        do_reset();
        chk(sclk == cfg_idle_high, "R1 sclk rest", sclk, cfg_idle_high);
        chk(sdo == 1'b0, "R1 sdo", sdo, 0);
        chk(drdy_n == 1'b1, "R1 drdy_n", drdy_n, 1);
        chk(setup_mode == 1'b0, "R1 setup_mode", setup_mode, 0);
        chk(meas_start == 1'b0, "R1 meas_start", meas_start, 0);
    endtask

    task automatic run_xfer(input logic [15:0] data, input int rate, input int gap, input bit ih);
        int p, g, guard, wait_n, errs;
        logic [15:0] got;
        p = 30 + 8 * rate;
        g = 10 + 4 * gap;
        cfg_rate = 8'(rate);
        cfg_gap = 8'(gap);
        cfg_idle_high = ih;
        repeat (2) @(negedge clk);
        chk(sclk == ih, "R7 rest level before", sclk, ih);
        nlead = 0; ntrail = 0; drdy_rise_t = -1; drdy_bad = 0; sdo_before_b1 = 1'b1;
        mon_idle = ih;
        mon_on = 1'b1;
        req_n = 1'b0;
        wait_n = 0;
        while (!meas_start && wait_n < 20) begin
            @(negedge clk);
            wait_n++;
        end
        chk(meas_start == 1'b1, "R2 start strobe", meas_start, 1);
        req_n = 1'b1;
        @(negedge clk);
        chk(meas_start == 1'b0, "R2 start one cycle", meas_start, 0);
        repeat (30) @(negedge clk);
        chk(nlead == 0 && drdy_n, "R2 quiet before done", nlead, 0);
        meas_data = data;
        meas_done = 1'b1;
        @(negedge clk);
        meas_done = 1'b0;
        meas_data = '0;
        guard = 0;
        while (drdy_rise_t < 0 && guard < 60000) begin
            @(negedge clk);
            guard++;
        end
        repeat (3) @(negedge clk);
        mon_on = 1'b0;
        chk(nlead == 16, "R3 bit count", nlead, 16);
        got = '0;
        for (int i = 0; i < 16; i++) got[15 - i] = lead_d[i];
        chk(got == data, "R3 data order", got, data);
        errs = 0;
        for (int i = 1; i < 16; i++)
            if (i != 8 && lead_t[i] - lead_t[i - 1] != p) errs++;
        chk(errs == 0, "R4 bit period", lead_t[1] - lead_t[0], p);
        errs = 0;
        for (int i = 0; i < 16; i++)
            if (trail_t[i] - lead_t[i] != p / 2) errs++;
        chk(errs == 0, "R5 active half", trail_t[0] - lead_t[0], p / 2);
        chk(lead_t[8] - lead_t[7] == p + g, "R6 byte gap", lead_t[8] - lead_t[7], p + g);
        chk(sdo_before_b1 == 1'b0, "R8 sdo low in gap", sdo_before_b1, 0);
        chk(sdo == 1'b0, "R8 sdo low after", sdo, 0);
        chk(sclk == ih, "R7 rest level after", sclk, ih);
        chk(drdy_bad == 0, "R9 drdy low at edges", drdy_bad, 0);
        chk(drdy_rise_t - lead_t[15] == p, "R9 drdy release", drdy_rise_t - lead_t[15], p);
    endtask

    task automatic test_setup_entry();
        int wait_n, starts;
        cfg_idle_high = 1'b0;
        cfg_rate = 8'd0;
        mon_idle = 1'b0;
        nlead = 0; ntrail = 0; drdy_rise_t = -1; drdy_bad = 0;
        mon_on = 1'b1;
        req_n = 1'b0;
        wait_n = 0;
        while (!meas_start && wait_n < 20) begin
            @(negedge clk);
            wait_n++;
        end
        repeat (5) @(negedge clk);
        meas_done = 1'b1;
        @(negedge clk);
        meas_done = 1'b0;
        @(negedge clk);
        chk(setup_mode == 1'b1, "R10 setup entered", setup_mode, 1);
        repeat (200) @(negedge clk);
        chk(nlead == 0, "R10 no transfer", nlead, 0);
        chk(drdy_n == 1'b1, "R10 drdy released", drdy_n, 1);
        req_n = 1'b1;
        repeat (3) @(negedge clk);
        req_n = 1'b0;
        starts = 0;
        repeat (50) begin
            @(negedge clk);
            if (meas_start) starts++;
        end
        req_n = 1'b1;
        mon_on = 1'b0;
        chk(starts == 0, "R10 requests ignored", starts, 0);
        chk(setup_mode == 1'b1, "R10 setup sticky", setup_mode, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        test_reset_state();
        run_xfer(16'hA5C3, 55, 148, 1'b0);
        run_xfer(16'h1F80, 0, 0, 1'b1);
        run_xfer(16'h0001, 3, 5, 1'b0);
        run_xfer(16'hFF00, 1, 2, 1'b1);
        test_setup_entry();
        cfg_idle_high = 1'b1;
        test_reset_state();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule